// File: doc/BRIEF.md
# Port Address Counter Register

This block produces the address that one port of a synchronous memory uses on each access. At every rising clock edge it picks one of four actions from three active-low controls. It can load an address supplied from outside, step the stored address up by one, keep the stored address, or force it to zero. The registered result drives the memory array directly. The address that is loaded, stepped or cleared at an edge is therefore the address accessed in the cycle that follows that edge.

Bursts use this in a simple way. The address is loaded once, and the counter then steps through successive locations without a new address on the bus. The step control can also stall the burst, so that the same location is read again. Clearing to zero takes effect at once, with no idle cycle, so an access to location 0 can happen in the cycle right after the clear. Chip enables and byte selects are not inputs here, so no such signal can block an action. The memory array and the data paths live elsewhere.

Top module: `port_addr_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `access_addr` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst_n` high and `clear_n` low at an edge, `access_addr` becomes 0 after that edge, even when `strobe_n` and `step_n` are low at the same time.
- R3: With `clear_n` high and `strobe_n` low at an edge, `access_addr` takes the value of `ext_addr` sampled at that edge.
- R4: With `clear_n` and `strobe_n` high and `step_n` low at an edge, `access_addr` becomes its previous value plus one.
- R5: With `clear_n`, `strobe_n` and `step_n` all high at an edge, `access_addr` keeps its value, and any change on `ext_addr` has no effect.
- R6: A step from the all-ones address gives address 0.
- R7: A clear followed directly by a step gives address 0 in the first cycle and address 1 in the next, with no idle cycle in between.
- R8: When `strobe_n` and `step_n` are both low, with `clear_n` high, the external address is loaded and is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | ADDR_W | Address offered for loading |
| strobe_n | input | 1 | Active-low load request |
| step_n | input | 1 | Active-low increment request |
| clear_n | input | 1 | Active-low clear to address 0 |
| access_addr | output | ADDR_W | Address used for the current access |

## Verification
The assertions check each of the four actions on every cycle by comparing the registered address with its value one edge earlier: zeroing on reset or clear, copying the sampled external address, adding one with wrap-around, and holding. They also check that clear wins over load and load wins over step. The following are shown only by the bench's ordered scenarios: the no-idle-cycle sequence from clear to step, a load from the all-ones address followed by a wrapping step, and a hold while the external bus changes.

// File: rtl/pac_pkg.sv
`timescale 1ns/1ps
// Shared types for the port address counter.
package pac_pkg;
    // Action chosen for one clock edge, listed from lowest to highest priority.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_ZERO = 2'd3
    } pac_act_e;
endpackage

// File: rtl/pac_action_decode.sv
`timescale 1ns/1ps
// Turns the three active-low controls into one action.
// Priority order: clear, then load, then step, then hold.
// Assumes the controls are already synchronous to the port clock.
module pac_action_decode
    import pac_pkg::*;
(
    input  logic     strobe_n,
    input  logic     step_n,
    input  logic     clear_n,
    output pac_act_e act
);
    // Priority encoder over the control inputs.
    always_comb begin
        if (!clear_n)       act = ACT_ZERO;
        else if (!strobe_n) act = ACT_LOAD;
        else if (!step_n)   act = ACT_STEP;
        else                act = ACT_HOLD;
    end
endmodule

// File: rtl/pac_incr.sv
`timescale 1ns/1ps
// Adds one to the address with a ripple chain of half adders.
// The carry out of the top bit is dropped, so all ones wraps to zero.
module pac_incr #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] inc
);
    logic [ADDR_W:0] carry;

    // Carry in of one starts the increment.
    assign carry[0] = 1'b1;

    // One half adder per address bit.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign inc[i]     = cur[i] ^ carry[i];
        assign carry[i+1] = cur[i] & carry[i];
    end
endmodule

// File: rtl/pac_next_sel.sv
`timescale 1ns/1ps
// Selects the next address value for the chosen action.
// Assumes inc is already cur plus one.
module pac_next_sel
    import pac_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  pac_act_e          act,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] ext,
    input  logic [ADDR_W-1:0] inc,
    output logic [ADDR_W-1:0] nxt
);
    // Four-way selection on the action.
    always_comb begin
        unique case (act)
            ACT_ZERO: nxt = '0;
            ACT_LOAD: nxt = ext;
            ACT_STEP: nxt = inc;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/port_addr_counter.sv
`timescale 1ns/1ps
// Address generator for one memory port. The address is registered, so
// the address loaded, stepped, held or cleared at an edge is the one
// accessed in the cycle after that edge. Chip enables and byte selects
// are not inputs, so nothing can stop an action.
// Assumes all inputs are synchronous to clk. Reset is synchronous and
// active low.
module port_addr_counter
    import pac_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              clear_n,
    output logic [ADDR_W-1:0] access_addr
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    pac_act_e          act;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_inc;
    logic [ADDR_W-1:0] addr_nxt;

    pac_action_decode u_dec (
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .clear_n  (clear_n),
        .act      (act)
    );

    pac_incr #(.ADDR_W(ADDR_W)) u_inc (
        .cur (addr_q),
        .inc (addr_inc)
    );

    pac_next_sel #(.ADDR_W(ADDR_W)) u_sel (
        .act (act),
        .cur (addr_q),
        .ext (ext_addr),
        .inc (addr_inc),
        .nxt (addr_nxt)
    );

    // Address register: reset, then the selected next value.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_nxt;
    end

    assign access_addr = addr_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> access_addr == '0);
    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> access_addr == '0);
    // R3 R8
    load_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !strobe_n) |=> access_addr == $past(ext_addr));
    // R4
    step_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && !step_n && $past(rst_n))
        |=> access_addr == ADDR_W'($past(access_addr) + 1'b1));
    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && step_n && $past(rst_n)) |=> $stable(access_addr));
    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && !step_n && access_addr == TOP_ADDR)
        |=> access_addr == '0);
endmodule

// File: tb/tb_port_addr_counter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task computes each expected address and
// queues it; the monitor compares at the falling edge.
module tb_port_addr_counter;
    localparam int AW = 15;

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic          clear_n = 1'b1;
    logic [AW-1:0] access_addr;

    sb_item_t      sb[$];
    sb_item_t      cur_item;
    logic [AW-1:0] model = '0;
    int            n_checks = 0;
    int            n_fails = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    port_addr_counter #(.ADDR_W(AW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_addr    (ext_addr),
        .strobe_n    (strobe_n),
        .step_n      (step_n),
        .clear_n     (clear_n),
        .access_addr (access_addr)
    );

    // Drive one cycle of controls and queue the expected address.
    task automatic drive(input logic rst, input logic s, input logic st,
                         input logic c, input logic [AW-1:0] ea,
                         input string tag);
        @(negedge clk);
        rst_n = rst; strobe_n = s; step_n = st; clear_n = c; ext_addr = ea;
        if (!rst)    model = '0;
        else if (!c) model = '0;
        else if (!s) model = ea;
        else if (!st) model = model + 1'b1;
        @(posedge clk);
        sb.push_back('{model, tag});
    endtask

    // Monitor: compare the output with the oldest queued item.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            cur_item = sb.pop_front();
            n_checks++;
            if (access_addr !== cur_item.exp) begin
                n_fails++;
                $display("FAIL %s: access_addr=%h expected=%h",
                         cur_item.tag, access_addr, cur_item.exp);
            end
        end
    end

    initial begin
        drive(0, 0, 0, 1, 15'h0555, "R1 reset");
        drive(0, 1, 1, 1, 15'h0000, "R1 reset held");
        drive(1, 0, 1, 1, 15'h1234, "R3 load");
        drive(1, 1, 0, 1, 15'h7777, "R4 step 1");
        drive(1, 1, 0, 1, 15'h0000, "R4 step 2");
        drive(1, 1, 0, 1, 15'h2222, "R4 step 3");
        drive(1, 1, 1, 1, 15'h5A5A, "R5 hold ext change");
        drive(1, 1, 1, 1, 15'h0F0F, "R5 hold again");
        drive(1, 0, 0, 0, 15'h3333, "R2 clear over load and step");
        drive(1, 1, 0, 1, 15'h4444, "R7 step after clear");
        drive(1, 1, 0, 1, 15'h4444, "R7 step to two");
        drive(1, 0, 0, 1, 15'h0100, "R8 load beats step");
        drive(1, 0, 1, 1, 15'h7FFF, "R3 load top");
        drive(1, 1, 0, 1, 15'h0000, "R6 wrap to zero");
        drive(1, 1, 0, 1, 15'h0000, "R6 step after wrap");
        drive(1, 0, 1, 1, 15'h2AAA, "R3 load pattern");
        drive(0, 0, 0, 1, 15'h1111, "R1 reset mid run");
        drive(1, 1, 1, 1, 15'h1111, "R5 hold after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end
endmodule